// File: doc/BRIEF.md
# Register-Mapped Single-Byte SPI Master

This block is an SPI master with one chip select, reached through a small 32-bit register bus. Software moves one 8-bit frame per command. For a transmit, it puts a byte in the data register and sets the start-transmit bit in the control register. For a receive, it sets the start-receive bit and reads the captured byte back once the busy flag has dropped. Transmit and receive are separate half-duplex commands. MISO is ignored during a transmit, and the MOSI content is irrelevant during a receive.

A configuration register holds the serial clock settings:
- the bit order;
- the idle level of SCK;
- which SCK edge launches MOSI bits, chosen independently of the idle level;
- which SCK edge samples MISO, also chosen independently of the idle level;
- a power-of-two prescaler.

The control register drives the chip select directly, with inverted sense, and sets the output enable of MOSI. The bus is a single-cycle strobe interface with combinational read data.

Top module: `regspi_master`

## Requirements
- R1: After reset the configuration register reads 0x153 (MSB first, SCK idle high, launch on falling edge, sample on rising edge, prescaler code 3) and the control register reads 0x9. Status reads 0, spi_cs_n and spi_sck are high, and spi_mosi_oe is low.
- R2: The registers sit at these byte offsets: status 0x00, configuration 0x10, control 0x14, data 0x20.
  - Configuration fields: bit 8 MSB-first, bit 6 SCK idle level, bit 5 sample on falling edge, bit 4 launch on falling edge, bits [2:0] prescaler code.
  - Control fields: bit 3 MOSI high impedance, bit 2 start transmit, bit 1 start receive, bit 0 chip-select release.
  - Data is held in bits [7:0]. Unimplemented bits read 0.
- R3: A control write with bit 2 or bit 1 set while idle makes status bit 0 (busy) read 1 from the next cycle. Busy then stays 1 for exactly 16·2^code system cycles, after which the start bits clear themselves. If both start bits are written together, the transmit command wins.
- R4: A transmit frame sends the 8 data bits on spi_mosi in the order set by configuration bit 8. MISO activity during the frame leaves the data register unchanged.
- R5: A receive frame shifts 8 bits from spi_miso, in the configured bit order, into data register bits [7:0].
- R6: Configuration bit 4 selects the falling SCK edge (1) or the rising edge (0) for changing MOSI. Bit 5 makes the same choice for sampling MISO. Both are independent of bit 6, and SCK rests at the level of bit 6 whenever no frame runs.
- R7: Prescaler codes 0 to 6 give an SCK period of 2^(code+1) system cycles.
- R8: Prescaler code 7 freezes SCK and the frame while busy stays 1. Writing a running code afterwards lets the frame resume and complete correctly.
- R9: A start command written while busy is 1 is ignored. The running frame and its type are unchanged.
- R10: spi_cs_n follows control bit 0 from the cycle after the write: clearing the bit drives it low and setting it drives it high.
- R11: spi_mosi_oe is the inverse of control bit 3 from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | Output enable for spi_mosi |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The checks assume the following about the bus:
- every access is a one-cycle strobe, so each control write is a single event;
- a rise of busy can always be traced to a start write in the previous cycle;
- the bit-order, edge and idle-level fields only change while no frame runs, since a frame takes its edge types from them as it goes.

The stimulus keeps to these assumptions. It drives the bus on the falling system clock edge and rewrites the configuration only between frames; the one exception is a prescaler change to leave the frozen state. The bench's serial slave changes spi_miso only on the SCK edges that are not sampling edges.

// File: rtl/regspi_pkg.sv
package regspi_pkg;

  localparam int unsigned DIV_W   = 3;
  localparam int unsigned FRAME_W = 8;

  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_CFG  = 8'h10;
  localparam logic [7:0] OFS_CTL  = 8'h14;
  localparam logic [7:0] OFS_DATA = 8'h20;

  localparam int unsigned CFG_MSB_BIT  = 8;
  localparam int unsigned CFG_CPOL_BIT = 6;
  localparam int unsigned CFG_RXF_BIT  = 5;
  localparam int unsigned CFG_TXF_BIT  = 4;

  localparam int unsigned CTL_HIZ_BIT = 3;
  localparam int unsigned CTL_WR_BIT  = 2;
  localparam int unsigned CTL_RD_BIT  = 1;
  localparam int unsigned CTL_EN_BIT  = 0;

  localparam logic [DIV_W-1:0] DIV_STOP = '1;

  typedef struct packed {
    logic             msb_first;
    logic             cpol;
    logic             rx_fall;
    logic             tx_fall;
    logic [DIV_W-1:0] div_code;
  } cfg_t;

  localparam cfg_t CFG_RST = '{msb_first: 1'b1, cpol: 1'b1, rx_fall: 1'b0,
                               tx_fall: 1'b1, div_code: 3'd3};

endpackage

// File: rtl/regspi_regs.sv
module regspi_regs
  import regspi_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               frame_done,
  input  logic [FRAME_W-1:0] rx_byte,
  output cfg_t               cfg_o,
  output logic [FRAME_W-1:0] tx_byte_o,
  output logic               start_o,
  output logic               busy_o,
  output logic               go_wr_o,
  output logic               go_rd_o,
  output logic               hiz_o,
  output logic               cs_rel_o
);

  cfg_t               cfg_q, cfg_d;
  logic [FRAME_W-1:0] data_q, data_d;
  logic               hiz_q, hiz_d;
  logic               rel_q, rel_d;
  logic               gowr_q, gowr_d;
  logic               gord_q, gord_d;

  logic wr_acc, wr_cfg, wr_ctl, wr_data, busy, start, rx_valid;
  logic unused_hi_bits;

  assign unused_hi_bits = ^bus_wdata[DATA_W-1:CFG_MSB_BIT+1];

  assign wr_acc  = bus_en & bus_we;
  assign wr_cfg  = wr_acc & (bus_addr == ADDR_W'(OFS_CFG));
  assign wr_ctl  = wr_acc & (bus_addr == ADDR_W'(OFS_CTL));
  assign wr_data = wr_acc & (bus_addr == ADDR_W'(OFS_DATA));

  assign busy     = gowr_q | gord_q;
  assign start    = wr_ctl & ~busy & (bus_wdata[CTL_WR_BIT] | bus_wdata[CTL_RD_BIT]);
  assign rx_valid = frame_done & gord_q;

  always_comb begin
    cfg_d  = cfg_q;
    data_d = data_q;
    hiz_d  = hiz_q;
    rel_d  = rel_q;
    gowr_d = gowr_q;
    gord_d = gord_q;

    if (wr_cfg) begin
      cfg_d.msb_first = bus_wdata[CFG_MSB_BIT];
      cfg_d.cpol      = bus_wdata[CFG_CPOL_BIT];
      cfg_d.rx_fall   = bus_wdata[CFG_RXF_BIT];
      cfg_d.tx_fall   = bus_wdata[CFG_TXF_BIT];
      cfg_d.div_code  = bus_wdata[DIV_W-1:0];
    end

    if (rx_valid) begin
      data_d = rx_byte;
    end else if (wr_data) begin
      data_d = bus_wdata[FRAME_W-1:0];
    end

    if (wr_ctl) begin
      hiz_d = bus_wdata[CTL_HIZ_BIT];
      rel_d = bus_wdata[CTL_EN_BIT];
    end

    if (frame_done) begin
      gowr_d = 1'b0;
      gord_d = 1'b0;
    end else if (start) begin
      gowr_d = bus_wdata[CTL_WR_BIT];
      gord_d = ~bus_wdata[CTL_WR_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_STAT): bus_rdata[0] = busy;
      ADDR_W'(OFS_CFG): begin
        bus_rdata[CFG_MSB_BIT]  = cfg_q.msb_first;
        bus_rdata[CFG_CPOL_BIT] = cfg_q.cpol;
        bus_rdata[CFG_RXF_BIT]  = cfg_q.rx_fall;
        bus_rdata[CFG_TXF_BIT]  = cfg_q.tx_fall;
        bus_rdata[DIV_W-1:0]    = cfg_q.div_code;
      end
      ADDR_W'(OFS_CTL): begin
        bus_rdata[CTL_HIZ_BIT] = hiz_q;
        bus_rdata[CTL_WR_BIT]  = gowr_q;
        bus_rdata[CTL_RD_BIT]  = gord_q;
        bus_rdata[CTL_EN_BIT]  = rel_q;
      end
      ADDR_W'(OFS_DATA): bus_rdata[FRAME_W-1:0] = data_q;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      data_q <= '0;
      hiz_q  <= 1'b1;
      rel_q  <= 1'b1;
      gowr_q <= 1'b0;
      gord_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      data_q <= data_d;
      hiz_q  <= hiz_d;
      rel_q  <= rel_d;
      gowr_q <= gowr_d;
      gord_q <= gord_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign tx_byte_o = data_q;
  assign start_o   = start;
  assign busy_o    = busy;
  assign go_wr_o   = gowr_q;
  assign go_rd_o   = gord_q;
  assign hiz_o     = hiz_q;
  assign cs_rel_o  = rel_q;

endmodule

// File: rtl/regspi_clkgen.sv
module regspi_clkgen
  import regspi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div_code,
  output logic             sck_o,
  output logic             edge_pulse_o,
  output logic             edge_rise_o
);

  localparam int unsigned HALF_MAX = 1 << ((1 << DIV_W) - 2);
  localparam int unsigned CNT_W    = $clog2(HALF_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             sck_q, sck_d;
  logic             stopped, tick;

  assign half_m1 = CNT_W'((32'd1 << div_code) - 32'd1);
  assign stopped = (div_code == DIV_STOP);
  assign tick    = busy & ~stopped & (cnt_q >= half_m1);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!busy) begin
      cnt_d = '0;
      sck_d = cpol;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else if (!stopped) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= CFG_RST.cpol;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o        = sck_q;
  assign edge_pulse_o = tick;
  assign edge_rise_o  = ~sck_q;

endmodule

// File: rtl/regspi_shifter.sv
module regspi_shifter
  import regspi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] load_byte,
  input  logic               edge_pulse,
  input  logic               edge_rise,
  input  logic               tx_fall,
  input  logic               rx_fall,
  input  logic               msb_first,
  input  logic               miso,
  output logic               mosi_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_byte_o
);

  localparam int unsigned EDGES = 2 * FRAME_W;
  localparam int unsigned EC_W  = $clog2(EDGES);

  logic [EC_W-1:0]    ecnt_q, ecnt_d;
  logic [FRAME_W-1:0] tx_q, tx_d, rx_q, rx_d, rx_next;
  logic               tx_edge, rx_edge;

  assign tx_edge = edge_pulse & (edge_rise ^ tx_fall);
  assign rx_edge = edge_pulse & (edge_rise ^ rx_fall);
  assign rx_next = msb_first ? {rx_q[FRAME_W-2:0], miso} : {miso, rx_q[FRAME_W-1:1]};
  assign done_o  = edge_pulse & (ecnt_q == EC_W'(EDGES - 1));

  always_comb begin
    ecnt_d = ecnt_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start) begin
      ecnt_d = '0;
      tx_d   = load_byte;
      rx_d   = '0;
    end else if (edge_pulse) begin
      ecnt_d = ecnt_q + EC_W'(1);
      if (tx_edge && (ecnt_q != '0)) begin
        tx_d = msb_first ? {tx_q[FRAME_W-2:0], 1'b0} : {1'b0, tx_q[FRAME_W-1:1]};
      end
      if (rx_edge) begin
        rx_d = rx_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      ecnt_q <= ecnt_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign mosi_o    = msb_first ? tx_q[FRAME_W-1] : tx_q[0];
  assign rx_byte_o = rx_edge ? rx_next : rx_q;

endmodule

// File: rtl/regspi_master.sv
module regspi_master
  import regspi_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_mosi_oe,
  input  logic              spi_miso,
  output logic              spi_cs_n
);

  cfg_t               cfg_cur;
  logic [FRAME_W-1:0] tx_byte, rx_byte;
  logic               start, busy, go_wr, go_rd, hiz, cs_rel;
  logic               frame_done, edge_pulse, edge_rise;

  regspi_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .frame_done (frame_done),
    .rx_byte    (rx_byte),
    .cfg_o      (cfg_cur),
    .tx_byte_o  (tx_byte),
    .start_o    (start),
    .busy_o     (busy),
    .go_wr_o    (go_wr),
    .go_rd_o    (go_rd),
    .hiz_o      (hiz),
    .cs_rel_o   (cs_rel)
  );

  regspi_clkgen clkgen_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .cpol         (cfg_cur.cpol),
    .div_code     (cfg_cur.div_code),
    .sck_o        (spi_sck),
    .edge_pulse_o (edge_pulse),
    .edge_rise_o  (edge_rise)
  );

  regspi_shifter shifter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .load_byte  (tx_byte),
    .edge_pulse (edge_pulse),
    .edge_rise  (edge_rise),
    .tx_fall    (cfg_cur.tx_fall),
    .rx_fall    (cfg_cur.rx_fall),
    .msb_first  (cfg_cur.msb_first),
    .miso       (spi_miso),
    .mosi_o     (spi_mosi),
    .done_o     (frame_done),
    .rx_byte_o  (rx_byte)
  );

  assign spi_cs_n    = cs_rel;
  assign spi_mosi_oe = ~hiz;

endmodule

// File: rtl/regspi_checker.sv
module regspi_checker
  import regspi_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        ctl_wdata,
  input logic              spi_sck,
  input logic              spi_mosi_oe,
  input logic              spi_cs_n,
  input logic              busy,
  input logic              go_wr,
  input logic              go_rd,
  input logic              cpol,
  input logic [DIV_W-1:0]  div_code
);

  logic wr_ctl;
  assign wr_ctl = bus_en & bus_we & (bus_addr == ADDR_W'(OFS_CTL));

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_ctl && (ctl_wdata[CTL_WR_BIT] || ctl_wdata[CTL_RD_BIT])));

  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_wr, go_rd}));

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> (spi_sck == $past(cpol)));

  assert_frozen_sck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && ($past(div_code) == DIV_STOP)) |-> $stable(spi_sck));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctl) |=> (({go_wr, go_rd} == $past({go_wr, go_rd})) || ({go_wr, go_rd} == 2'b00)));

  assert_cs_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (spi_cs_n == $past(ctl_wdata[CTL_EN_BIT])));

  assert_oe_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (spi_mosi_oe == !$past(ctl_wdata[CTL_HIZ_BIT])));

endmodule

bind regspi_master regspi_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .ctl_wdata   (bus_wdata[3:0]),
  .spi_sck     (spi_sck),
  .spi_mosi_oe (spi_mosi_oe),
  .spi_cs_n    (spi_cs_n),
  .busy        (busy),
  .go_wr       (go_wr),
  .go_rd       (go_rd),
  .cpol        (cfg_cur.cpol),
  .div_code    (cfg_cur.div_code)
);

// File: tb/regspi_master_tb_top.sv
module regspi_master_tb_top;

  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_CFG  = 8'h10;
  localparam logic [7:0] A_CTL  = 8'h14;
  localparam logic [7:0] A_DATA = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_mosi_oe, spi_miso, spi_cs_n;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // serial slave model state
  bit        slv_on = 1'b0;
  logic      slv_msb = 1'b1, slv_txf = 1'b0, slv_rxf = 1'b0;
  logic [7:0] slv_pat = '0, slv_cap = '0;
  logic [2:0] slv_bit = '0;
  int        slv_cnt = 0;

  always #4 clk = ~clk;

  regspi_master dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .spi_sck     (spi_sck),
    .spi_mosi    (spi_mosi),
    .spi_mosi_oe (spi_mosi_oe),
    .spi_miso    (spi_miso),
    .spi_cs_n    (spi_cs_n)
  );

  assign spi_miso = slv_msb ? slv_pat[3'd7 - slv_bit] : slv_pat[slv_bit];

  // Slave samples MOSI on the edge type the master does not launch on,
  // and moves MISO on the edge type the master does not sample on.
  always @(spi_sck) begin
    if (slv_on) begin
      if (spi_sck == slv_txf)
        slv_cap = slv_msb ? {slv_cap[6:0], spi_mosi} : {spi_mosi, slv_cap[7:1]};
      if (spi_sck == slv_rxf && slv_cnt != 0 && slv_bit != 3'd7)
        slv_bit = slv_bit + 3'd1;
      slv_cnt++;
    end
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic poll_idle(output int cyc);
    logic [31:0] s;
    cyc = 0;
    while (1) begin
      bus_rd(A_STAT, s);
      if (s[0] == 1'b0 || cyc > 20000) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic slave_arm(input logic [31:0] cfgv, input logic [7:0] pat);
    slv_msb = cfgv[8]; slv_txf = cfgv[4]; slv_rxf = cfgv[5];
    slv_pat = pat; slv_bit = '0; slv_cnt = 0; slv_cap = '0;
    slv_on = 1'b1;
  endtask

  task automatic do_frame(input bit rd, input logic [31:0] cfgv, input logic [7:0] txb,
                          input logic [7:0] pat, output logic [7:0] cap,
                          output logic [7:0] dat, output int cyc);
    logic [31:0] d;
    bus_wr(A_CFG, cfgv);
    if (!rd) bus_wr(A_DATA, {24'h0, txb});
    slave_arm(cfgv, pat);
    bus_wr(A_CTL, rd ? 32'h2 : 32'h4);
    poll_idle(cyc);
    slv_on = 1'b0;
    cap = slv_cap;
    bus_rd(A_DATA, d);
    dat = d[7:0];
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(A_CFG, d);  check_eq("R1 cfg reset", d, 32'h153);
    bus_rd(A_CTL, d);  check_eq("R1 ctl reset", d, 32'h9);
    bus_rd(A_STAT, d); check_eq("R1 status reset", d, 32'h0);
    check_eq("R1 cs_n reset", spi_cs_n, 1'b1);
    check_eq("R1 oe reset", spi_mosi_oe, 1'b0);
    check_eq("R1 sck reset", spi_sck, 1'b1);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_wr(A_DATA, 32'h0001_2345);
    bus_rd(A_DATA, d); check_eq("R2 data readback", d, 32'h45);
    bus_wr(A_CFG, 32'hFFFF_FFFF);
    bus_rd(A_CFG, d);  check_eq("R2 cfg field mask", d, 32'h177);
    bus_wr(A_CFG, 32'h153);
    bus_wr(A_CTL, 32'h0);
    bus_rd(A_CTL, d);  check_eq("R2 ctl readback", d, 32'h0);
    check_eq("R10 cs_n low", spi_cs_n, 1'b0);
    check_eq("R11 oe high", spi_mosi_oe, 1'b1);
    bus_wr(A_CTL, 32'h9);
    check_eq("R10 cs_n high", spi_cs_n, 1'b1);
    check_eq("R11 oe low", spi_mosi_oe, 1'b0);
    bus_wr(A_CTL, 32'h0);
  endtask

  task automatic t_frames;
    logic [7:0] cap, dat;
    int cyc;
    // cpol 0, launch falling, sample rising, MSB first, code 0
    do_frame(1'b0, 32'h110, 8'hA5, 8'h3C, cap, dat, cyc);
    check_eq("R4 tx msb mosi", cap, 8'hA5);
    check_eq("R4 miso ignored", dat, 8'hA5);
    check_eq("R7 code0 busy cycles", cyc, 16);
    check_eq("R6 idle sck cpol0", spi_sck, 1'b0);
    check_eq("R10 cs held low", spi_cs_n, 1'b0);
    do_frame(1'b1, 32'h110, 8'h00, 8'h3C, cap, dat, cyc);
    check_eq("R5 rx msb", dat, 8'h3C);
    // cpol 1, launch rising, sample falling, LSB first, code 1
    do_frame(1'b0, 32'h061, 8'h96, 8'h00, cap, dat, cyc);
    check_eq("R4 tx lsb mosi", cap, 8'h96);
    check_eq("R7 code1 busy cycles", cyc, 32);
    check_eq("R6 idle sck cpol1", spi_sck, 1'b1);
    do_frame(1'b1, 32'h061, 8'h00, 8'hC3, cap, dat, cyc);
    check_eq("R5 rx lsb", dat, 8'hC3);
    // cpol 0, launch rising, sample falling
    do_frame(1'b0, 32'h120, 8'h5A, 8'hFF, cap, dat, cyc);
    check_eq("R6 tx rising launch", cap, 8'h5A);
    do_frame(1'b1, 32'h120, 8'h00, 8'hE1, cap, dat, cyc);
    check_eq("R6 rx falling sample", dat, 8'hE1);
    // cpol 1, launch falling, sample rising, code 3
    do_frame(1'b0, 32'h153, 8'h81, 8'h00, cap, dat, cyc);
    check_eq("R6 tx cpol1 falling", cap, 8'h81);
    check_eq("R7 code3 busy cycles", cyc, 128);
    do_frame(1'b1, 32'h153, 8'h00, 8'h6D, cap, dat, cyc);
    check_eq("R5 rx cpol1 rising", dat, 8'h6D);
  endtask

  task automatic t_both_bits;
    logic [31:0] d;
    int cyc;
    bus_wr(A_CFG, 32'h110);
    bus_wr(A_DATA, 32'h4E);
    slave_arm(32'h110, 8'h11);
    bus_wr(A_CTL, 32'h6);
    bus_rd(A_CTL, d); check_eq("R3 write wins", d, 32'h4);
    bus_rd(A_STAT, d); check_eq("R3 busy next cycle", d, 32'h1);
    poll_idle(cyc);
    slv_on = 1'b0;
    check_eq("R3 frame sent", slv_cap, 8'h4E);
    bus_rd(A_CTL, d); check_eq("R3 start bits cleared", d, 32'h0);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    int cyc;
    int moved = 0;
    bus_wr(A_CFG, 32'h117);
    bus_wr(A_DATA, 32'h3E);
    slave_arm(32'h117, 8'h00);
    bus_wr(A_CTL, 32'h4);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (spi_sck !== 1'b0) moved++;
    end
    check_eq("R8 sck frozen", moved, 0);
    bus_rd(A_STAT, d); check_eq("R8 busy held", d, 32'h1);
    bus_wr(A_CFG, 32'h110);
    poll_idle(cyc);
    slv_on = 1'b0;
    check_eq("R8 frame resumes", slv_cap, 8'h3E);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    int cyc;
    bus_wr(A_CFG, 32'h111);
    bus_wr(A_DATA, 32'hB7);
    slave_arm(32'h111, 8'h5C);
    bus_wr(A_CTL, 32'h4);
    bus_wr(A_CTL, 32'h2);
    bus_rd(A_CTL, d); check_eq("R9 type kept", d[2:1], 2'b10);
    poll_idle(cyc);
    slv_on = 1'b0;
    check_eq("R9 tx intact", slv_cap, 8'hB7);
    bus_rd(A_DATA, d); check_eq("R9 no receive", d, 32'hB7);
    bus_rd(A_STAT, d); check_eq("R9 idle after", d, 32'h0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_frames();
    t_both_bits();
    t_stop();
    t_ignore();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule